// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block multiplies two 16-bit operands and adds the product into a 40-bit accumulator, made of a 32-bit result field and 8 guard bits. Each operand carries its own signed/unsigned selector, so signed, unsigned and mixed products are all available. A 16-bit control word, written through a small register port with byte strobes, selects two arithmetic modes. The first doubles signed-by-signed products. The second clamps each result to the signed 32-bit range.

Every accumulate updates four status flags: carry, sticky overflow, extension and sticky limit. Software can clear any of them through a clear vector. A level interrupt request is raised when a flag is set, its own mask bit in the control word is set, and the global enable bit is set.

A host drives `mac_go` for one cycle per accumulate. It can reset the accumulator with `acc_clr` or preload it with `acc_ld`/`ld_val`. The result appears on `acc` one clock after the strobe.

Top module: `mac_sat_unit`

## Requirements
- R1: With `mac_go` high, `acc` takes, one cycle later, its previous value plus `op_a*op_b`. Each operand is read as two's complement when its `*_signed` input is 1 and as unsigned otherwise. The sum wraps modulo 2^40.
- R2: When control bit 1 (shift mode) is 1 and both `a_signed` and `b_signed` are 1, the product is doubled before it is added. Unsigned and mixed products are never doubled.
- R3: When control bit 0 (saturation mode) is 1, a result outside [-2^31, 2^31-1] is replaced by the nearest bound, sign-extended to 40 bits. The direction follows the true, unwrapped sum. The limit flag `flags[3]` is then set, and it stays set until it is cleared.
- R4: `flags[0]` (carry) holds the carry out of bit 39 of the unsigned 40-bit addition in the last accumulate. `flags[1]` (overflow) is set by a 40-bit signed overflow and stays set until it is cleared.
- R5: `flags[2]` (extension) is set by an accumulate when saturation mode is 0 and result bits 39..31 are not all equal. Otherwise an accumulate clears it.
- R6: `irq` is registered. It equals control bit 15 (global enable) ANDed with the OR of `flags[i]` AND control bit 8+i, for i = 0..3, all sampled one cycle earlier.
- R7: The control word resets to 0000h. Only bits 0, 1, 8 to 11 and 15 are stored. All other bits ignore writes and read as 0, so writing FFFFh reads back 8F03h.
- R8: A write with `reg_be`=11 loads both bytes. A write with 01 loads the low byte and zeroes the high byte. A write with 10 loads the high byte and zeroes the low byte. A write with 00 changes nothing.
- R9: `acc_clr` zeroes the accumulator and has priority over `acc_ld`, which in turn has priority over `mac_go`. Both clear `flags[0]` and `flags[2]`.
- R10: A 1 in `flag_clr[i]` clears `flags[i]` at the next edge, unless an accumulate in the same cycle sets it again. Reset clears all flags, `acc` and `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Control word write strobe |
| reg_be | input | 2 | Byte strobes for the control write |
| reg_wdata | input | 16 | Control write data |
| reg_rdata | output | 16 | Control word read value |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| a_signed | input | 1 | First operand is two's complement |
| b_signed | input | 1 | Second operand is two's complement |
| mac_go | input | 1 | Accumulate strobe |
| acc_clr | input | 1 | Clear accumulator |
| acc_ld | input | 1 | Load accumulator from ld_val |
| ld_val | input | 40 | Accumulator load value |
| flag_clr | input | 4 | Per-flag clear |
| acc | output | 40 | Accumulator |
| flags | output | 4 | {limit, extension, overflow, carry} |
| irq | output | 1 | Interrupt request (level) |

## Verification
The bench builds the block with its defaults, OP_W=16 and GUARD_W=8. With these values the extreme operands are reachable: the largest unsigned square, and -32768 squared, which becomes exactly 2^31 when doubled. Preloading the accumulator at the 40-bit and 32-bit bounds drives both the wrap into the guard bits and the clamp in either direction. All of these corner values are therefore checked against hand-computed results.

// File: rtl/mac_sat_unit.sv
module mac_sat_unit #(
  parameter int OP_W    = 16,
  parameter int GUARD_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reg_wr,
  input  logic [1:0]                    reg_be,
  input  logic [15:0]                   reg_wdata,
  output logic [15:0]                   reg_rdata,
  input  logic [OP_W-1:0]               op_a,
  input  logic [OP_W-1:0]               op_b,
  input  logic                          a_signed,
  input  logic                          b_signed,
  input  logic                          mac_go,
  input  logic                          acc_clr,
  input  logic                          acc_ld,
  input  logic [2*OP_W+GUARD_W-1:0]     ld_val,
  input  logic [3:0]                    flag_clr,
  output logic [2*OP_W+GUARD_W-1:0]     acc,
  output logic [3:0]                    flags,
  output logic                          irq
);
  localparam int RES_W = 2 * OP_W;
  localparam int ACC_W = RES_W + GUARD_W;
  localparam int PR_W  = 2 * (OP_W + 1);
  localparam int B_SAT = 0, B_SHF = 1, B_MSK = 8, B_IEN = 15;
  localparam logic [15:0] IMPL = 16'h8F03;
  localparam logic [ACC_W-1:0] HI_LIM = {{(GUARD_W+1){1'b0}}, {(RES_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] LO_LIM = {{(GUARD_W+1){1'b1}}, {(RES_W-1){1'b0}}};
  localparam int F_C = 0, F_V = 1, F_E = 2, F_L = 3;

  logic [15:0]      ctl_q;
  logic [ACC_W-1:0] acc_q, acc_n;
  logic [3:0]       f_q, f_n;
  logic             irq_q;

  // control word: a partial byte write zeroes the other byte
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ctl_q <= '0;
    else if (reg_wr && reg_be != 2'b00)
      ctl_q <= {reg_be[1] ? reg_wdata[15:8] : 8'h00,
                reg_be[0] ? reg_wdata[7:0]  : 8'h00} & IMPL;

  wire sat_en = ctl_q[B_SAT];
  wire do_shf = ctl_q[B_SHF] & a_signed & b_signed;

  wire signed [OP_W:0]   a_x = {a_signed & op_a[OP_W-1], op_a};
  wire signed [OP_W:0]   b_x = {b_signed & op_b[OP_W-1], op_b};
  wire signed [PR_W-1:0] prod_raw = a_x * b_x;
  wire signed [ACC_W-1:0] prod_ext = ACC_W'(prod_raw);
  wire [ACC_W-1:0] prod = do_shf ? (prod_ext <<< 1) : prod_ext;

  wire [ACC_W:0]   usum  = {1'b0, acc_q} + {1'b0, prod};
  wire [ACC_W-1:0] raw   = usum[ACC_W-1:0];
  wire             carry = usum[ACC_W];
  wire             ovf   = (acc_q[ACC_W-1] == prod[ACC_W-1]) && (raw[ACC_W-1] != acc_q[ACC_W-1]);
  wire             tsign = ovf ? acc_q[ACC_W-1] : raw[ACC_W-1];
  wire             guard_ok = (raw[ACC_W-1:RES_W-1] == '0) || (raw[ACC_W-1:RES_W-1] == '1);
  wire             fits  = guard_ok && !ovf;
  wire             clamp = sat_en && !fits;
  wire [ACC_W-1:0] res   = clamp ? (tsign ? LO_LIM : HI_LIM) : raw;

  always_comb begin
    acc_n = acc_q;
    f_n   = f_q & ~flag_clr;
    if (acc_clr) begin
      acc_n = '0;
      f_n[F_C] = 1'b0;
      f_n[F_E] = 1'b0;
    end else if (acc_ld) begin
      acc_n = ld_val;
      f_n[F_C] = 1'b0;
      f_n[F_E] = 1'b0;
    end else if (mac_go) begin
      acc_n = res;
      f_n[F_C] = carry;
      f_n[F_E] = !sat_en && !guard_ok;
      f_n[F_V] = f_n[F_V] | ovf;
      f_n[F_L] = f_n[F_L] | clamp;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      acc_q <= '0;
      f_q   <= '0;
      irq_q <= 1'b0;
    end else begin
      acc_q <= acc_n;
      f_q   <= f_n;
      irq_q <= ctl_q[B_IEN] & |(f_q & ctl_q[B_MSK +: 4]);
    end

  assign reg_rdata = ctl_q;
  assign acc       = acc_q;
  assign flags     = f_q;
  assign irq       = irq_q;

  assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q[B_IEN] |=> !irq);

  assert_sat_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_en && mac_go && !acc_clr && !acc_ld) |=>
      ($signed(acc) <= $signed(HI_LIM) && $signed(acc) >= $signed(LO_LIM)));

  assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[F_V] && !flag_clr[F_V]) |=> flags[F_V]);

  assert_byte_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_be == 2'b01) |=> (reg_rdata[15:8] == 8'h00));

  assert_clr_prio_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_clr |=> (acc == '0 && !flags[F_C] && !flags[F_E]));

  assert_ext_sat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_en && mac_go && !acc_clr && !acc_ld) |=> !flags[F_E]);
endmodule

// File: tb/mac_sat_unit_tb.sv
module mac_sat_unit_tb;
  logic        clk = 0, rst_n = 0;
  logic        reg_wr = 0;
  logic [1:0]  reg_be = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic [15:0] op_a = 0, op_b = 0;
  logic        a_signed = 0, b_signed = 0, mac_go = 0, acc_clr = 0, acc_ld = 0;
  logic [39:0] ld_val = 0, acc;
  logic [3:0]  flag_clr = 0, flags;
  logic        irq;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  mac_sat_unit u_dut (.*);

  // {ctl, init, a, b, sa, sb, exp_acc, exp_flags{L,E,V,C}}
  localparam int NV = 12;
  localparam logic [133:0] VEC [NV] = '{
    {16'h0000, 40'h0000000000, 16'h0003, 16'h0005, 1'b0, 1'b0, 40'h000000000F, 4'h0},
    {16'h0000, 40'h000000000A, 16'hFFFF, 16'h0002, 1'b1, 1'b1, 40'h0000000008, 4'h1},
    {16'h0002, 40'h0000000000, 16'hFFFF, 16'h0003, 1'b1, 1'b1, 40'hFFFFFFFFFA, 4'h0},
    {16'h0002, 40'h0000000000, 16'hFFFF, 16'h0003, 1'b1, 1'b0, 40'hFFFFFFFFFD, 4'h0},
    {16'h0002, 40'h0000000000, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 40'h00FFFE0001, 4'h4},
    {16'h0001, 40'h0000000000, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 40'h007FFFFFFF, 4'h8},
    {16'h0001, 40'hFF80000000, 16'h0001, 16'hFFFF, 1'b1, 1'b1, 40'hFF80000000, 4'h9},
    {16'h0000, 40'h7FFFFFFFFF, 16'h0001, 16'h0001, 1'b0, 1'b0, 40'h8000000000, 4'h6},
    {16'h0001, 40'h7FFFFFFFFF, 16'h0001, 16'h0001, 1'b0, 1'b0, 40'h007FFFFFFF, 4'hA},
    {16'h0002, 40'h0000000000, 16'h8000, 16'h8000, 1'b1, 1'b1, 40'h0080000000, 4'h4},
    {16'h0003, 40'h0000000000, 16'h8000, 16'h8000, 1'b1, 1'b1, 40'h007FFFFFFF, 4'h8},
    {16'h0002, 40'h0000000000, 16'h8000, 16'hFFFF, 1'b0, 1'b1, 40'hFFFFFF8000, 4'h0}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] be, input logic [15:0] d);
    reg_wr = 1; reg_be = be; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_be = 0;
  endtask

  task automatic prep(input logic [39:0] v);
    flag_clr = 4'hF; acc_ld = 1; ld_val = v;
    @(negedge clk);
    flag_clr = 0; acc_ld = 0;
  endtask

  task automatic op(input logic [15:0] a, input logic [15:0] b, input logic sa, input logic sb);
    op_a = a; op_b = b; a_signed = sa; b_signed = sb; mac_go = 1;
    @(negedge clk);
    mac_go = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state (R7, R10)
    chk("R7 reset ctl", reg_rdata, 16'h0000);
    chk("R10 reset acc", acc, 0);
    chk("R10 reset flags", flags, 0);
    chk("R10 reset irq", irq, 0);
    rst_n = 1;
    @(negedge clk);

    wr(2'b11, 16'hFFFF);
    chk("R7 unimplemented bits", reg_rdata, 16'h8F03);
    wr(2'b01, 16'h00FF);
    chk("R8 low byte write", reg_rdata, 16'h0003);
    wr(2'b10, 16'hFF00);
    chk("R8 high byte write", reg_rdata, 16'h8F00);
    wr(2'b00, 16'h0000);
    chk("R8 no strobe", reg_rdata, 16'h8F00);

    for (int i = 0; i < NV; i++) begin
      wr(2'b11, VEC[i][133:118]);
      prep(VEC[i][117:78]);
      op(VEC[i][77:62], VEC[i][61:46], VEC[i][45], VEC[i][44]);
      chk($sformatf("R1 R2 R3 vec%0d acc", i), acc, VEC[i][43:4]);
      chk($sformatf("R4 R5 vec%0d flags", i), flags, VEC[i][3:0]);
    end

    // sticky overflow (R4) and selective clear (R10)
    wr(2'b11, 16'h0000);
    prep(40'h7FFFFFFFFF);
    op(16'h0001, 16'h0001, 0, 0);
    op(16'h0000, 16'h0000, 0, 0);
    chk("R4 overflow sticky", flags, 4'h6);
    flag_clr = 4'b0010;
    @(negedge clk);
    flag_clr = 0;
    chk("R10 clear overflow only", flags, 4'h4);

    // priority (R9)
    prep(40'h0);
    ld_val = 40'd123; acc_ld = 1;
    op(16'h0003, 16'h0005, 0, 0);
    acc_ld = 0;
    chk("R9 load beats accumulate", acc, 40'd123);
    acc_clr = 1; acc_ld = 1;
    op(16'h0003, 16'h0005, 0, 0);
    acc_clr = 0; acc_ld = 0;
    chk("R9 clear beats load", acc, 0);

    // interrupt (R6)
    wr(2'b11, 16'h8400);
    prep(40'h0);
    op(16'hFFFF, 16'hFFFF, 0, 0);
    chk("R6 irq not yet", irq, 0);
    @(negedge clk);
    chk("R6 irq raised", irq, 1);
    wr(2'b11, 16'h8000);
    @(negedge clk);
    chk("R6 masked flag no irq", irq, 0);
    wr(2'b11, 16'h0400);
    @(negedge clk);
    chk("R6 global disable", irq, 0);
    wr(2'b11, 16'h8400);
    @(negedge clk);
    chk("R6 irq re-enabled", irq, 1);
    flag_clr = 4'b0100;
    @(negedge clk);
    flag_clr = 0;
    chk("R6 irq one cycle after clear", irq, 1);
    @(negedge clk);
    chk("R6 irq dropped", irq, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule